// File: doc/BRIEF.md
# SS7 Receive Signal-Unit Filter

This block sits behind an HDLC deframer on a signalling-link receiver. The deframer has already removed the flags and the bit stuffing and has checked the CRC. It delivers each signal unit as a byte stream. The first octet is marked as the start. The unit then closes with an end strobe that carries the CRC verdict, or it is cut short by an abort strobe. The filter works out the type of each unit from its length indicator. It checks the unit's length, and it drops fill-in units whose content repeats the last accepted one. Link-status units are dropped on the same rule when that option is enabled.

Every unit that is kept is written to a receive FIFO write port. The octets go out in arrival order, including the two CRC octets, and one status byte follows them. The status byte carries the type, a CRC error bit, a length error bit and an abort bit.

The first seven octets of a unit are held back in a small stage. This lets a short unit be dropped whole, before any of its octets reach the FIFO. Longer units flow through with a delay of seven octets. Once a unit closes, the stage is emptied at one octet per cycle. The source must therefore leave at least ten cycles between the end or abort strobe of one unit and the start octet of the next.

Top module: `ss7_su_filter`

## Requirements
- R1: Status bits [1:0] give the unit type, taken from the length indicator (the low six bits of the third octet): 0 gives 00 (fill-in), 1 or 2 gives 01 (link status), and more than 2 gives 10 (message). A unit of fewer than three octets reports 00.
- R2: A fill-in unit is written nowhere when all of the following hold: its CRC is good, it has 5 to 7 octets, and its non-CRC octets (all but the last two) match the reference in both count and value.
- R3: The rule of R2 applies to link-status units only while `lssu_dedup_en_i` is 1. Message units are never dropped.
- R4: A unit of fewer than five octets gets status bit 3 set and is always written.
- R5: While `long_chk_en_i` is 1, the arrival of a 279th octet ends the unit. The first 278 octets are written, followed by a status byte with bits 3 and 4 set. A unit of exactly 278 octets is kept unchanged. While `long_chk_en_i` is 0, there is no upper limit.
- R6: A kept unit writes every octet in arrival order, including the two CRC octets, and then exactly one status byte. Status bits [7:5] are 0.
- R7: A unit with a bad CRC gets status bit 2 set. It is never dropped, and it leaves the reference unchanged.
- R8: An abort strobe during a unit writes the octets received so far, followed by a status byte with bit 4 set.
- R9: After reset no write occurs until a unit arrives, and the reference is empty, so the first fill-in unit is kept.
- R10: The reference is replaced by every good-CRC fill-in or link-status unit of 5 to 7 octets. Message units, aborted units and errored units leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lssu_dedup_en_i | input | 1 | Enables duplicate dropping for link-status units |
| long_chk_en_i | input | 1 | Enables the 278-octet upper length limit |
| rx_valid_i | input | 1 | An octet is present on rx_data_i |
| rx_data_i | input | 8 | Received octet |
| rx_sof_i | input | 1 | Marks the first octet of a unit |
| rx_end_i | input | 1 | Closing strobe of a unit, with no data |
| rx_crc_ok_i | input | 1 | CRC verdict, valid with rx_end_i |
| rx_abort_i | input | 1 | Abort strobe for the current unit |
| wr_en_o | output | 1 | FIFO write strobe |
| wr_data_o | output | 8 | FIFO write data: a unit octet or the status byte |

## Verification
The assertions run on every cycle and check the guarantees about keeping units. A unit with a bad CRC, a short unit, an aborted unit, and a link-status unit that closes while dropping is disabled must all go on to be written. The arrival of the 279th octet under the long check must end reception. Every status byte must have a legal type and clear upper bits. Only the bench scenarios can show the content comparison itself: that drops follow the reference from one unit to the next, that a bad CRC leaves the reference alone, and that the exact octet sequence and status value reach the FIFO for each unit.

// File: rtl/ss7f_pkg.sv
package ss7f_pkg;

  typedef enum logic [1:0] {
    SU_FISU = 2'b00,
    SU_LSSU = 2'b01,
    SU_MSU  = 2'b10
  } su_type_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_RECV,
    ST_DRAIN,
    ST_STAT
  } fsm_e;

  localparam int unsigned STAT_CRC_BIT = 2;
  localparam int unsigned STAT_LEN_BIT = 3;
  localparam int unsigned STAT_ABT_BIT = 4;

  function automatic su_type_e su_classify(logic [5:0] li, logic have_li);
    if (!have_li || li == 6'd0) return SU_FISU;
    if (li <= 6'd2)             return SU_LSSU;
    return SU_MSU;
  endfunction

  function automatic logic [7:0] mk_status(su_type_e t, logic crc_err,
                                           logic len_err, logic abt);
    logic [7:0] s;
    s               = '0;
    s[1:0]          = t;
    s[STAT_CRC_BIT] = crc_err;
    s[STAT_LEN_BIT] = len_err;
    s[STAT_ABT_BIT] = abt;
    return s;
  endfunction

endpackage

// File: rtl/ss7f_stage.sv
// Holds the oldest DEPTH octets of a unit; once full, each push shifts one out at head_o.
module ss7f_stage #(
  parameter int unsigned DEPTH = 7,
  parameter int unsigned W     = 8,
  parameter int unsigned TAP   = 5
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             clr_i,
  input  logic             push_i,
  input  logic             pop_i,
  input  logic [W-1:0]     data_i,
  output logic [W-1:0]     head_o,
  output logic             full_o,
  output logic             empty_o,
  output logic [TAP*W-1:0] tap_o
);
  localparam int unsigned FW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem_q [DEPTH];
  logic [FW-1:0] fill_q;

  assign full_o  = (fill_q == FW'(DEPTH));
  assign empty_o = (fill_q == '0);
  assign head_o  = mem_q[0];

  for (genvar g = 0; g < TAP; g++) begin : g_tap
    assign tap_o[g*W +: W] = mem_q[g];
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fill_q <= '0;
      for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
    end else if (clr_i) begin
      fill_q <= '0;
    end else if (push_i) begin
      if (full_o) begin
        for (int i = 0; i < DEPTH - 1; i++) mem_q[i] <= mem_q[i+1];
        mem_q[DEPTH-1] <= data_i;
      end else begin
        mem_q[fill_q] <= data_i;
        fill_q        <= fill_q + 1'b1;
      end
    end else if (pop_i && !empty_o) begin
      for (int i = 0; i < DEPTH - 1; i++) mem_q[i] <= mem_q[i+1];
      fill_q <= fill_q - 1'b1;
    end
  end
endmodule

// File: rtl/ss7f_ref.sv
// Copy of the last accepted short unit; match_o compares a candidate of cand_len_i octets.
module ss7f_ref #(
  parameter int unsigned N  = 5,
  parameter int unsigned W  = 8,
  parameter int unsigned LW = $clog2(N + 1)
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           upd_i,
  input  logic [N*W-1:0] cand_i,
  input  logic [LW-1:0]  cand_len_i,
  output logic           match_o
);
  logic [N*W-1:0] ref_q;
  logic [LW-1:0]  len_q;
  logic           vld_q;
  logic [N-1:0]   eq;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign eq[g] = (cand_len_i <= LW'(g)) || (ref_q[g*W +: W] == cand_i[g*W +: W]);
  end

  assign match_o = vld_q && (len_q == cand_len_i) && (&eq);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ref_q <= '0;
      len_q <= '0;
      vld_q <= 1'b0;
    end else if (upd_i) begin
      ref_q <= cand_i;
      len_q <= cand_len_i;
      vld_q <= 1'b1;
    end
  end
endmodule

// File: rtl/ss7_su_filter.sv
module ss7_su_filter
  import ss7f_pkg::*;
#(
  parameter int unsigned MAX_SIF   = 272,
  parameter int unsigned STAGE     = 7,
  parameter int unsigned REF_BYTES = 5,
  parameter int unsigned MIN_OCT   = 5
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       lssu_dedup_en_i,
  input  logic       long_chk_en_i,
  input  logic       rx_valid_i,
  input  logic [7:0] rx_data_i,
  input  logic       rx_sof_i,
  input  logic       rx_end_i,
  input  logic       rx_crc_ok_i,
  input  logic       rx_abort_i,
  output logic       wr_en_o,
  output logic [7:0] wr_data_o
);
  // header (BSN, FSN, LI, SIO) + SIF + 2 CRC
  localparam int unsigned MAX_OCT = MAX_SIF + 6;
  localparam int unsigned CNT_W   = $clog2(MAX_OCT + 2);
  localparam int unsigned LW      = $clog2(REF_BYTES + 1);
  localparam logic [CNT_W-1:0] MAX_OCT_C = CNT_W'(MAX_OCT);
  localparam logic [CNT_W-1:0] MIN_OCT_C = CNT_W'(MIN_OCT);
  localparam logic [CNT_W-1:0] STAGE_C   = CNT_W'(STAGE);
  localparam logic [CNT_W-1:0] CNT_SAT   = '1;

  fsm_e              state_q;
  logic [CNT_W-1:0]  cnt_q;
  logic [5:0]        li_q;
  logic [7:0]        stat_q;
  logic              wr_en_q;
  logic [7:0]        wr_data_q;

  logic              st_push, st_pop, st_clr, st_full, st_empty;
  logic [7:0]        st_head;
  logic [REF_BYTES*8-1:0] st_tap;
  logic              ref_match, ref_upd;
  logic [LW-1:0]     cand_len;

  su_type_e cur_type;
  logic     short_unit, small_unit, dedup_ok, drop, long_hit;
  logic     in_recv, rx_sof_byte;

  assign cur_type    = su_classify(li_q, cnt_q >= CNT_W'(3));
  assign short_unit  = cnt_q < MIN_OCT_C;
  assign small_unit  = cnt_q <= STAGE_C;
  assign cand_len    = LW'(cnt_q - CNT_W'(2));
  assign in_recv     = (state_q == ST_RECV) && !rx_abort_i;
  assign rx_sof_byte = rx_valid_i && rx_sof_i;

  assign dedup_ok = rx_crc_ok_i && !short_unit && small_unit &&
                    ((cur_type == SU_FISU) || ((cur_type == SU_LSSU) && lssu_dedup_en_i));
  assign drop     = in_recv && rx_end_i && dedup_ok && ref_match;
  assign ref_upd  = in_recv && rx_end_i && rx_crc_ok_i && !short_unit &&
                    small_unit && (cur_type != SU_MSU);
  assign long_hit = in_recv && !rx_end_i && rx_valid_i && long_chk_en_i &&
                    (cnt_q == MAX_OCT_C);

  assign st_push = ((state_q == ST_IDLE) && rx_sof_byte) ||
                   (in_recv && !rx_end_i && rx_valid_i && !long_hit);
  assign st_pop  = (state_q == ST_DRAIN);
  assign st_clr  = drop;

  ss7f_stage #(.DEPTH(STAGE), .W(8), .TAP(REF_BYTES)) u_stage (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .clr_i   (st_clr),
    .push_i  (st_push),
    .pop_i   (st_pop),
    .data_i  (rx_data_i),
    .head_o  (st_head),
    .full_o  (st_full),
    .empty_o (st_empty),
    .tap_o   (st_tap)
  );

  ss7f_ref #(.N(REF_BYTES), .W(8), .LW(LW)) u_ref (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .upd_i      (ref_upd),
    .cand_i     (st_tap),
    .cand_len_i (cand_len),
    .match_o    (ref_match)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q   <= ST_IDLE;
      cnt_q     <= '0;
      li_q      <= '0;
      stat_q    <= '0;
      wr_en_q   <= 1'b0;
      wr_data_q <= '0;
    end else begin
      wr_en_q <= 1'b0;
      unique case (state_q)
        ST_IDLE: begin
          if (rx_sof_byte) begin
            cnt_q   <= CNT_W'(1);
            li_q    <= '0;
            state_q <= ST_RECV;
          end
        end
        ST_RECV: begin
          if (rx_abort_i) begin
            stat_q  <= mk_status(cur_type, 1'b0, 1'b0, 1'b1);
            state_q <= ST_DRAIN;
          end else if (rx_end_i) begin
            stat_q  <= mk_status(cur_type, !rx_crc_ok_i, short_unit, 1'b0);
            state_q <= drop ? ST_IDLE : ST_DRAIN;
          end else if (long_hit) begin
            stat_q  <= mk_status(cur_type, 1'b0, 1'b1, 1'b1);
            state_q <= ST_DRAIN;
          end else if (rx_valid_i) begin
            if (cnt_q == CNT_W'(2)) li_q <= rx_data_i[5:0];
            if (cnt_q != CNT_SAT)   cnt_q <= cnt_q + 1'b1;
            if (st_full) begin
              wr_en_q   <= 1'b1;
              wr_data_q <= st_head;
            end
          end
        end
        ST_DRAIN: begin
          if (!st_empty) begin
            wr_en_q   <= 1'b1;
            wr_data_q <= st_head;
          end else begin
            state_q <= ST_STAT;
          end
        end
        ST_STAT: begin
          wr_en_q   <= 1'b1;
          wr_data_q <= stat_q;
          state_q   <= ST_IDLE;
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign wr_en_o   = wr_en_q;
  assign wr_data_o = wr_data_q;

endmodule

// File: rtl/ss7f_chk.sv
module ss7f_chk
  import ss7f_pkg::*;
#(
  parameter int unsigned MAX_SIF = 272,
  parameter int unsigned MIN_OCT = 5,
  parameter int unsigned CNT_W   = $clog2(MAX_SIF + 8)
) (
  input logic             clk_i,
  input logic             rst_ni,
  input fsm_e             state_i,
  input logic [CNT_W-1:0] cnt_i,
  input logic [5:0]       li_i,
  input logic             lssu_en_i,
  input logic             long_en_i,
  input logic             rx_valid_i,
  input logic             rx_end_i,
  input logic             rx_crc_ok_i,
  input logic             rx_abort_i,
  input logic             wr_en_i,
  input logic [7:0]       wr_data_i
);
  logic recv_end;
  assign recv_end = (state_i == ST_RECV) && !rx_abort_i && rx_end_i;

  AST_STATUS_FORMAT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_i == ST_STAT) |=> (wr_en_i && wr_data_i[7:5] == 3'b000 && wr_data_i[1:0] != 2'b11)); // R1

  AST_WR_ONLY_IN_UNIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |-> ($past(state_i) != ST_IDLE)); // R9

  AST_BAD_CRC_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (recv_end && !rx_crc_ok_i) |=> (state_i == ST_DRAIN)); // R7

  AST_SHORT_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (recv_end && cnt_i < CNT_W'(MIN_OCT)) |=> (state_i == ST_DRAIN)); // R4

  AST_LSSU_KEPT_OFF: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (recv_end && !lssu_en_i && cnt_i >= CNT_W'(3) && (li_i == 6'd1 || li_i == 6'd2))
      |=> (state_i == ST_DRAIN)); // R3

  AST_LONG_CUT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_i == ST_RECV) && !rx_abort_i && !rx_end_i && rx_valid_i && long_en_i &&
     cnt_i == CNT_W'(MAX_SIF + 6)) |=> (state_i == ST_DRAIN)); // R5

  AST_ABORT_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((state_i == ST_RECV) && rx_abort_i) |=> (state_i == ST_DRAIN)); // R8

endmodule

bind ss7_su_filter ss7f_chk u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .state_i     (state_q),
  .cnt_i       (cnt_q),
  .li_i        (li_q),
  .lssu_en_i   (lssu_dedup_en_i),
  .long_en_i   (long_chk_en_i),
  .rx_valid_i  (rx_valid_i),
  .rx_end_i    (rx_end_i),
  .rx_crc_ok_i (rx_crc_ok_i),
  .rx_abort_i  (rx_abort_i),
  .wr_en_i     (wr_en_o),
  .wr_data_i   (wr_data_o)
);

// File: tb/sim_ss7_su_filter.sv
`timescale 1ns/1ps
module sim_ss7_su_filter;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       lssu_en = 1'b0, long_en = 1'b0;
  logic       rx_valid = 1'b0, rx_sof = 1'b0, rx_end = 1'b0, rx_crc_ok = 1'b0, rx_abort = 1'b0;
  logic [7:0] rx_data = '0;
  logic       wr_en;
  logic [7:0] wr_data;

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;
  logic [7:0] got [$];
  logic [7:0] exp_q [$];

  always #10 clk = ~clk;

  ss7_su_filter u0 (
    .clk_i(clk), .rst_ni(rst_n),
    .lssu_dedup_en_i(lssu_en), .long_chk_en_i(long_en),
    .rx_valid_i(rx_valid), .rx_data_i(rx_data), .rx_sof_i(rx_sof),
    .rx_end_i(rx_end), .rx_crc_ok_i(rx_crc_ok), .rx_abort_i(rx_abort),
    .wr_en_o(wr_en), .wr_data_o(wr_data)
  );

  always @(negedge clk) if (rst_n && wr_en) got.push_back(wr_data);

  // n octets, first octet in bits [55:48]
  typedef struct packed {
    logic [3:0]  n;
    logic [55:0] b;
    logic        crc;
    logic        lsen;
    logic        keep;
    logic [7:0]  st;
  } vec_t;

  localparam vec_t VEC [16] = '{
    '{4'd5, 56'h010200C1C20000, 1'b1, 1'b0, 1'b1, 8'h00},
    '{4'd5, 56'h010200C1C20000, 1'b1, 1'b0, 1'b0, 8'h00},
    '{4'd5, 56'h030400D1D20000, 1'b0, 1'b0, 1'b1, 8'h04},
    '{4'd5, 56'h010200C1C20000, 1'b1, 1'b0, 1'b0, 8'h00},
    '{4'd5, 56'h030400D1D20000, 1'b1, 1'b0, 1'b1, 8'h00},
    '{4'd6, 56'h05060107E1E200, 1'b1, 1'b0, 1'b1, 8'h01},
    '{4'd6, 56'h05060107E1E200, 1'b1, 1'b0, 1'b1, 8'h01},
    '{4'd6, 56'h05060107E1E200, 1'b1, 1'b1, 1'b0, 8'h01},
    '{4'd7, 56'h0506020708E3E4, 1'b1, 1'b1, 1'b1, 8'h01},
    '{4'd7, 56'h0506020708E3E4, 1'b1, 1'b1, 1'b0, 8'h01},
    '{4'd7, 56'h090A031122F1F2, 1'b1, 1'b1, 1'b1, 8'h02},
    '{4'd7, 56'h090A031122F1F2, 1'b1, 1'b1, 1'b1, 8'h02},
    '{4'd5, 56'h030400D1D20000, 1'b1, 1'b1, 1'b1, 8'h00},
    '{4'd4, 56'h01020099000000, 1'b1, 1'b0, 1'b1, 8'h08},
    '{4'd2, 56'h01020000000000, 1'b1, 1'b0, 1'b1, 8'h08},
    '{4'd4, 56'h01020399000000, 1'b1, 1'b0, 1'b1, 8'h0A}
  };

  function automatic string vtag(int i);
    case (i)
      0:       return "R9 first fill-in kept";
      1, 3:    return "R2 repeated fill-in dropped";
      2:       return "R7 bad CRC kept, reference kept";
      4, 12:   return "R10 changed content kept";
      5, 6:    return "R3 link status kept while disabled";
      7, 9:    return "R3 link status dropped while enabled";
      8:       return "R10 link status reference replaced";
      10, 11:  return "R1 message type, never dropped";
      13, 14:  return "R4 short unit flagged";
      default: return "R1 short unit type from LI";
    endcase
  endfunction

  task automatic put_byte(input logic [7:0] b, input logic sof);
    @(negedge clk); rx_valid = 1'b1; rx_data = b; rx_sof = sof;
    @(negedge clk); rx_valid = 1'b0; rx_sof = 1'b0;
  endtask

  task automatic close_unit(input logic crc, input logic abt);
    @(negedge clk); rx_end = !abt; rx_abort = abt; rx_crc_ok = crc;
    @(negedge clk); rx_end = 1'b0; rx_abort = 1'b0; rx_crc_ok = 1'b0;
    repeat (14) @(negedge clk);
  endtask

  task automatic compare(input string tag);
    int bad_at = -1;
    n_chk++;
    if (got.size() != exp_q.size()) bad_at = -2;
    else foreach (got[i]) if (bad_at == -1 && got[i] !== exp_q[i]) bad_at = i;
    if (bad_at == -2) begin
      n_bad++;
      $display("FAIL %s: wrote %0d bytes, expected %0d", tag, got.size(), exp_q.size());
    end else if (bad_at >= 0) begin
      n_bad++;
      $display("FAIL %s: byte %0d actual %02h expected %02h", tag, bad_at, got[bad_at], exp_q[bad_at]);
    end
    got.delete();
    exp_q.delete();
  endtask

  task automatic long_unit(input int n, input logic lim, input string tag);
    logic [7:0] b;
    long_en = lim;
    for (int k = 0; k < n; k++) begin
      b = (k == 2) ? 8'h3F : 8'(k);
      put_byte(b, k == 0);
      if (!(lim && k >= 278)) exp_q.push_back(b);
    end
    close_unit(1'b1, 1'b0);
    exp_q.push_back((lim && n > 278) ? 8'h1A : 8'h02);
    compare(tag);
    long_en = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung, expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] b;
    // R9: reset state
    repeat (3) @(negedge clk);
    n_chk++;
    if (wr_en !== 1'b0) begin
      n_bad++; $display("FAIL R9 reset: wr_en actual %b expected 0", wr_en);
    end
    rst_n = 1'b1;
    repeat (5) @(negedge clk);
    n_chk++;
    if (got.size() != 0) begin
      n_bad++; $display("FAIL R9 idle: writes actual %0d expected 0", got.size());
    end
    got.delete();

    foreach (VEC[i]) begin
      lssu_en = VEC[i].lsen;
      for (int k = 0; k < int'(VEC[i].n); k++) begin
        b = VEC[i].b[55 - 8*k -: 8];
        put_byte(b, k == 0);
        if (VEC[i].keep) exp_q.push_back(b);
      end
      close_unit(VEC[i].crc, 1'b0);
      if (VEC[i].keep) exp_q.push_back(VEC[i].st);
      compare(vtag(i));
    end
    lssu_en = 1'b0;

    // R8: abort after four octets of a message unit
    put_byte(8'h09, 1'b1); put_byte(8'h0A, 1'b0); put_byte(8'h03, 1'b0); put_byte(8'h11, 1'b0);
    close_unit(1'b0, 1'b1);
    exp_q = '{8'h09, 8'h0A, 8'h03, 8'h11, 8'h12};
    compare("R8 abort after four octets");

    // R8: abort after two octets
    put_byte(8'h55, 1'b1); put_byte(8'h66, 1'b0);
    close_unit(1'b0, 1'b1);
    exp_q = '{8'h55, 8'h66, 8'h10};
    compare("R8 abort after two octets");

    // R6/R1: 12-octet message flows through the stage
    for (int k = 0; k < 12; k++) begin
      b = (k == 2) ? 8'h08 : 8'(8'hA0 + k);
      put_byte(b, k == 0);
      exp_q.push_back(b);
    end
    close_unit(1'b0, 1'b0);
    exp_q.push_back(8'h06);
    compare("R6 long message order with bad CRC");

    long_unit(278, 1'b1, "R5 exactly 278 octets kept");
    long_unit(279, 1'b1, "R5 279th octet truncates");
    long_unit(279, 1'b0, "R5 no limit when disabled");

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule